// File: doc/BRIEF.md
# Big-Endian Byte and Word Load/Store Steering Unit

This unit connects the load/store port of a processor to a memory that is 16 bits wide and word organised. Software uses byte addresses across a 64 KB space. The unit turns each request into one word transaction on the memory. The word index is the byte address without its lowest bit. The unit also drives per-lane write enables and lays the store data onto the correct lane. On a load, it takes the returned word and extracts the load result from it. Words are stored big-endian. The byte at the even address is bits 15:8 of the word. The byte at the next odd address is bits 7:0.

A request is offered with `req_valid` and has three attributes. The size flag selects a byte or a word access. The write flag selects a store or a load. The address is a byte address. The unit accepts a request on every cycle and applies no back-pressure, so there is no ready signal. Memory-side outputs follow the request in the same cycle. The memory is expected to return read data on the clock edge that ends the request cycle. One cycle later, `load_valid` rises, and `load_data` carries the extracted result. A word request at an odd address is not sent to memory. Instead it raises `misalign_err` for one cycle, aligned with the response slot.

Top module: `be_lsu16`

## Requirements
- R1: For an accepted request, `mem_en` is high in the same cycle and `mem_word_addr` equals `req_addr[15:1]`. With `req_valid` low, `mem_en` is low.
- R2: A word store at an even address drives `mem_wr_en` = 2'b11 and passes `req_wdata` to `mem_wdata` unchanged.
- R3: A byte store drives exactly one enable. At an even address, `mem_wr_en` = 2'b10 and the byte `req_wdata[7:0]` sits in `mem_wdata[15:8]`. At an odd address, `mem_wr_en` = 2'b01 and the byte sits in `mem_wdata[7:0]`.
- R4: A byte store leaves the other byte of the same memory word unchanged, as seen by a later word load.
- R5: A word load returns the byte at the even address in bits 15:8 and the byte at the odd address in bits 7:0.
- R6: A byte load returns the addressed byte in bits 7:0 and zero in bits 15:8. The lane is chosen by address bit 0 (0 = bits 15:8 of the memory word, 1 = bits 7:0).
- R7: `load_valid` is high for exactly the one cycle after an accepted load. It stays low after stores, after misaligned requests and in idle cycles.
- R8: A word request at an odd address asserts no `mem_en` and no write enable, and leaves memory unchanged. It raises `misalign_err` for the following cycle and produces no `load_valid`.
- R9: A byte request never raises `misalign_err`, whatever its address.
- R10: After reset, and until a request arrives, `load_valid`, `misalign_err` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Store data; byte stores use bits 7:0 |
| mem_en | output | 1 | Memory transaction strobe |
| mem_word_addr | output | 15 | Word index to memory |
| mem_wr_en | output | 2 | Lane write enables, bit 1 = bits 15:8 |
| mem_wdata | output | 16 | Lane-steered write data |
| mem_rdata | input | 16 | Word returned by memory one edge after a read |
| load_valid | output | 1 | Load result present |
| load_data | output | 16 | Extracted load result |
| misalign_err | output | 1 | Previous request was a word access at an odd address |

## Verification
The hardest case to reach is a byte store into a word whose other byte holds known, distinct data, followed by a readback showing that only one lane changed. Random traffic alone rarely revisits the same word in that order. The bench therefore starts with directed sequences: a word store, byte stores to each lane with non-zero upper store data, then word and byte loads of the same word. After that it issues seeded random traffic over a narrow window of addresses, so words are revisited often. Misaligned word stores are aimed at words whose contents the shadow model already knows, so any stray write would show up on the next load.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;

  typedef enum logic {
    SZ_WORD = 1'b0,
    SZ_BYTE = 1'b1
  } acc_size_e;

  typedef struct packed {
    logic      load;
    logic      err;
    acc_size_e size;
  } pend_ctl_t;

endpackage

// File: rtl/be_lsu_align.sv
module be_lsu_align #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 1
) (
  input  logic                    valid_i,
  input  be_lsu_pkg::acc_size_e   size_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic                    go_o,
  output logic                    misalign_o,
  output logic [ADDR_W-OFF_W-1:0] word_addr_o,
  output logic [OFF_W-1:0]        offset_o
);
  import be_lsu_pkg::*;

  logic off_nonzero;

  // Word accesses must start on a word boundary; byte accesses may not fault.
  assign off_nonzero = |addr_i[OFF_W-1:0];
  assign misalign_o  = valid_i && (size_i == SZ_WORD) && off_nonzero;
  assign go_o        = valid_i && !misalign_o;
  assign word_addr_o = addr_i[ADDR_W-1:OFF_W];
  assign offset_o    = addr_i[OFF_W-1:0];

endmodule

// File: rtl/be_lsu_store.sv
module be_lsu_store #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int LANES  = DATA_W / BYTE_W,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic                  go_i,
  input  logic                  write_i,
  input  be_lsu_pkg::acc_size_e size_i,
  input  logic [OFF_W-1:0]      offset_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [LANES-1:0]      wr_en_o,
  output logic [DATA_W-1:0]     wdata_o
);
  import be_lsu_pkg::*;

  logic is_byte;
  assign is_byte = (size_i == SZ_BYTE);

  // Big-endian: byte offset k occupies the k-th slice counted from the MSB,
  // and its enable is bit LANES-1-k.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int HI = DATA_W - 1 - k * BYTE_W;
    logic hit;
    assign hit = !is_byte || (offset_i == OFF_W'(k));
    assign wr_en_o[LANES-1-k] = go_i && write_i && hit;
    assign wdata_o[HI -: BYTE_W] = is_byte ? wdata_i[BYTE_W-1:0]
                                           : wdata_i[HI -: BYTE_W];
  end

endmodule

// File: rtl/be_lsu_load.sv
module be_lsu_load #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int LANES  = DATA_W / BYTE_W,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic                  valid_i,
  input  be_lsu_pkg::acc_size_e size_i,
  input  logic [OFF_W-1:0]      offset_i,
  input  logic [DATA_W-1:0]     rdata_i,
  output logic [DATA_W-1:0]     data_o
);
  import be_lsu_pkg::*;

  logic [BYTE_W-1:0] lane_sel;

  always_comb begin
    lane_sel = '0;
    for (int k = 0; k < LANES; k++) begin
      if (offset_i == OFF_W'(k)) begin
        lane_sel = rdata_i[DATA_W-1-k*BYTE_W -: BYTE_W];
      end
    end
  end

  always_comb begin
    if (!valid_i) begin
      data_o = '0;
    end else if (size_i == SZ_BYTE) begin
      data_o = {{(DATA_W-BYTE_W){1'b0}}, lane_sel};
    end else begin
      data_o = rdata_i;
    end
  end

endmodule

// File: rtl/be_lsu16.sv
module be_lsu16 #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int OFF_W = $clog2(LANES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_byte,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               mem_en,
  output logic [WADDR_W-1:0] mem_word_addr,
  output logic [LANES-1:0]   mem_wr_en,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               load_valid,
  output logic [DATA_W-1:0]  load_data,
  output logic               misalign_err
);
  import be_lsu_pkg::*;

  acc_size_e        size;
  logic             go;
  logic             misalign;
  logic [OFF_W-1:0] offset;

  assign size = req_byte ? SZ_BYTE : SZ_WORD;

  be_lsu_align #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_align (
    .valid_i     (req_valid),
    .size_i      (size),
    .addr_i      (req_addr),
    .go_o        (go),
    .misalign_o  (misalign),
    .word_addr_o (mem_word_addr),
    .offset_o    (offset)
  );

  be_lsu_store #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_store (
    .go_i     (go),
    .write_i  (req_write),
    .size_i   (size),
    .offset_i (offset),
    .wdata_i  (req_wdata),
    .wr_en_o  (mem_wr_en),
    .wdata_o  (mem_wdata)
  );

  assign mem_en = go;

  // Response slot: control captured at the request edge, data taken from
  // the synchronous-read memory in the following cycle.
  pend_ctl_t        pend_q;
  logic [OFF_W-1:0] pend_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '{load: 1'b0, err: 1'b0, size: SZ_WORD};
      pend_off_q <= '0;
    end else begin
      pend_q.load <= go && !req_write;
      pend_q.err  <= misalign;
      pend_q.size <= size;
      pend_off_q  <= offset;
    end
  end

  be_lsu_load #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_load (
    .valid_i  (pend_q.load),
    .size_i   (pend_q.size),
    .offset_i (pend_off_q),
    .rdata_i  (mem_rdata),
    .data_o   (load_data)
  );

  assign load_valid   = pend_q.load;
  assign misalign_err = pend_q.err;

endmodule

// File: rtl/be_lsu16_chk.sv
module be_lsu16_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int OFF_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_byte,
  input logic [ADDR_W-1:0] req_addr,
  input logic              mem_en,
  input logic [LANES-1:0]  mem_wr_en,
  input logic              load_valid,
  input logic [DATA_W-1:0] load_data,
  input logic              misalign_err
);

  logic odd_word;
  assign odd_word = req_valid && !req_byte && (|req_addr[OFF_W-1:0]);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !mem_en && (mem_wr_en == '0));

  assert_word_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && req_write && !req_byte |-> (mem_wr_en == {LANES{1'b1}}));

  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && req_write && req_byte |-> $countones(mem_wr_en) == 1);

  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid && $past(req_byte) |-> load_data[DATA_W-1:BYTE_W] == '0);

  assert_load_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && !odd_word |=> load_valid);

  assert_no_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !load_valid);

  assert_misalign_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    odd_word |-> !mem_en && (mem_wr_en == '0));

  assert_misalign_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    odd_word |=> misalign_err && !load_valid);

  assert_byte_noerr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_byte |=> !misalign_err);

endmodule

bind be_lsu16 be_lsu16_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_byte     (req_byte),
  .req_addr     (req_addr),
  .mem_en       (mem_en),
  .mem_wr_en    (mem_wr_en),
  .load_valid   (load_valid),
  .load_data    (load_data),
  .misalign_err (misalign_err)
);

// File: tb/be_lsu16_tb.sv
module be_lsu16_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_byte = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        mem_en;
  logic [14:0] mem_word_addr;
  logic [1:0]  mem_wr_en;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        load_valid;
  logic [15:0] load_data;
  logic        misalign_err;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  be_lsu16 dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_en(mem_en), .mem_word_addr(mem_word_addr), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .load_valid(load_valid),
    .load_data(load_data), .misalign_err(misalign_err)
  );

  // Small synchronous memory model: 256 words, aliased by word index.
  logic [15:0] mem_model [256];
  logic [7:0]  shadow [512];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_wr_en[1]) mem_model[mem_word_addr[7:0]][15:8] <= mem_wdata[15:8];
      if (mem_wr_en[0]) mem_model[mem_word_addr[7:0]][7:0]  <= mem_wdata[7:0];
      if (mem_wr_en == 2'b00) mem_rdata <= mem_model[mem_word_addr[7:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_we(input bit wr, input bit byt,
                                        input logic [15:0] a);
    if (!wr || (!byt && a[0])) return 2'b00;
    if (!byt) return 2'b11;
    return a[0] ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [15:0] exp_load(input bit byt, input logic [15:0] a);
    logic [8:0] e;
    e = {a[8:1], 1'b0};
    if (byt) return {8'h00, shadow[a[8:0]]};
    return {shadow[e], shadow[e + 9'd1]};
  endfunction

  task automatic do_op(input bit wr, input bit byt, input logic [15:0] a,
                       input logic [15:0] wd);
    bit          go;
    logic [1:0]  we;
    logic [15:0] ld_exp;
    go = byt || !a[0];
    we = exp_we(wr, byt, a);
    ld_exp = exp_load(byt, a);
    req_valid = 1'b1; req_write = wr; req_byte = byt; req_addr = a; req_wdata = wd;
    #1;
    chk(mem_en == go, go ? "R1" : "R8", 32'(mem_en), 32'(go));
    if (go) chk(mem_word_addr == a[15:1], "R1", 32'(mem_word_addr), 32'(a[15:1]));
    chk(mem_wr_en == we, byt ? "R3" : (go ? "R2" : "R8"), 32'(mem_wr_en), 32'(we));
    if (wr && go && !byt)
      chk(mem_wdata == wd, "R2", 32'(mem_wdata), 32'(wd));
    if (wr && byt && !a[0])
      chk(mem_wdata[15:8] == wd[7:0], "R3", 32'(mem_wdata[15:8]), 32'(wd[7:0]));
    if (wr && byt && a[0])
      chk(mem_wdata[7:0] == wd[7:0], "R3", 32'(mem_wdata[7:0]), 32'(wd[7:0]));
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(load_valid == (go && !wr), "R7", 32'(load_valid), 32'(go && !wr));
    chk(misalign_err == !go, byt ? "R9" : "R8", 32'(misalign_err), 32'(!go));
    if (go && !wr)
      chk(load_data == ld_exp, byt ? "R6" : "R5", 32'(load_data), 32'(ld_exp));
    if (wr && go) begin
      if (byt) shadow[a[8:0]] = wd[7:0];
      else begin
        shadow[{a[8:1], 1'b0}] = wd[15:8];
        shadow[{a[8:1], 1'b1}] = wd[7:0];
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int j = 0; j < 512; j++) shadow[j] = 8'(j * 37 + 5);
    for (int i = 0; i < 256; i++) mem_model[i] = {shadow[2*i], shadow[2*i+1]};
    repeat (3) @(negedge clk);
    #1;
    chk(load_valid == 1'b0, "R10", 32'(load_valid), 32'd0);
    chk(misalign_err == 1'b0, "R10", 32'(misalign_err), 32'd0);
    chk(mem_en == 1'b0, "R10", 32'(mem_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(load_valid == 1'b0 && misalign_err == 1'b0, "R10",
        32'({load_valid, misalign_err}), 32'd0);

    // Directed: big-endian layout and lane isolation (R4, R5, R6).
    do_op(1, 0, 16'h1000, 16'h1234);
    do_op(0, 1, 16'h1000, 16'h0);        // R6 expect 0x0012
    do_op(0, 1, 16'h1001, 16'h0);        // R6 expect 0x0034
    do_op(1, 1, 16'h1001, 16'hCCAB);     // R3/R4 odd lane only
    do_op(0, 0, 16'h1000, 16'h0);        // R4 expect 0x12AB
    chk(load_data == 16'h0000, "R7", 32'(load_data), 32'd0);
    do_op(1, 1, 16'h1000, 16'hFF77);     // R3/R4 even lane only
    do_op(0, 0, 16'h1000, 16'h0);        // R4 expect 0x77AB
    // Misaligned word store must not disturb memory (R8).
    do_op(1, 0, 16'h1001, 16'hDEAD);
    do_op(0, 0, 16'h1000, 16'h0);
    do_op(1, 0, 16'h0FFF, 16'hBEEF);
    do_op(0, 0, 16'h0FFE, 16'h0);
    do_op(0, 0, 16'h1001, 16'h0);        // misaligned load: no response (R8)
    // Address extremes.
    do_op(1, 0, 16'hFFFE, 16'hA55A);
    do_op(0, 1, 16'hFFFF, 16'h0);
    do_op(1, 1, 16'hFFFF, 16'h0011);     // R9 odd byte store, no error
    do_op(0, 0, 16'hFFFE, 16'h0);
    do_op(0, 1, 16'h0000, 16'h0);

    // Constrained random over a narrow window to force word reuse.
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      bit wr, byt;
      wr  = 1'($urandom % 2);
      byt = 1'($urandom % 2);
      a   = {16'($urandom) & 16'hF000} | 16'($urandom % 32);
      if (!byt && ($urandom % 6 != 0)) a[0] = 1'b0;
      do_op(wr, byt, a, 16'($urandom));
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule